// File: doc/BRIEF.md
# Programming Status Read Path

This block is the read-data path of a byte-wide nonvolatile memory. While the memory is idle, a read access returns the byte that the array presents for the current address. A read access is chip-enable low, output-enable low and write-enable high. While the write controller reports that internal programming is under way, a read returns a status word instead of array data. A host can then detect the end of programming in one of two ways: it can poll the top bit against the data it last wrote, or it can watch a bit that changes on every read.

The block takes four things as inputs: the three active-low access strobes, the busy flag from the write controller, the last byte written, and the array's read data. It drives a data word and an output-enable for the bus pad. The write controller holds busy for the whole program time. That includes a write attempt that was refused and only starts the timer, so such attempts also produce status reads. Array storage and write sequencing live elsewhere.

The design has two state machines. The drive-mode machine has the states `DRV_HIZ`, `DRV_ARRAY` and `DRV_STATUS`, and it moves between them on each clock:
- to `DRV_HIZ` whenever there is no read access;
- to `DRV_STATUS` on a read while busy;
- to `DRV_ARRAY` on a read while idle.

The programming tracker has the states `PRG_IDLE` and `PRG_ACTIVE`, with two transitions:
- `PRG_IDLE`→`PRG_ACTIVE` when busy is seen high. This is the start of a programming period, and it clears the toggle bit.
- `PRG_ACTIVE`→`PRG_IDLE` when busy is seen low.

Top module: `rdstat_readback`

## Requirements
- R1: While `rst_n` is low, and in the cycle after reset is applied, `dq_oe` is 0 and `dq_out` is 0. The toggle bit is cleared by reset.
- R2: One clock after an edge where `ce_n` is 1, `oe_n` is 1 or `we_n` is 0, `dq_oe` is 0 and `dq_out` is 0x00.
- R3: One clock after an edge with a read access (`ce_n`=0, `oe_n`=0, `we_n`=1) and `prog_busy`=0, `dq_oe` is 1 and `dq_out` equals `array_rdata` as sampled at that edge.
- R4: One clock after a read access with `prog_busy`=1, `dq_out` bit 7 is the inverse of bit 7 of `last_wr_byte`.
- R5: One clock after a read access with `prog_busy`=1, `dq_out` bits 5..0 are the inverse of bits 5..0 of `last_wr_byte`.
- R6: While busy, the toggle bit driven on `dq_out` bit 6 inverts at the start of each read access, which is an edge where a read is present and none was present at the previous edge. Holding a read for several cycles does not change it.
- R7: The toggle bit is forced to 0 at the first edge where busy is seen high. A read that starts at that same edge therefore shows bit 6 = 1.
- R8: After busy falls, reads return the array byte on all eight bits, and bit 6 no longer changes from one read to the next.
- R9: A read that is already in progress when busy rises switches to the status word one clock later, with no new read start needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| prog_busy | input | 1 | High while internal programming (or a refused-write timer) runs |
| last_wr_byte | input | DATA_W | Last byte accepted by the write controller |
| array_rdata | input | DATA_W | Byte read from the array at the current address |
| dq_out | output | DATA_W | Read data toward the pad, 0 when not driven |
| dq_oe | output | 1 | Pad output enable; 0 means high impedance |

## Verification
The inputs are sampled on a rising edge, and every result appears after the next rising edge: drive mode, output enable, data word and toggle bit all have exactly one cycle of latency. The bench applies each stimulus on a falling edge, lets one rising edge pass, and compares on the next falling edge. Toggle history is carried across consecutive vectors. This means each expected bit 6 follows from the count of read starts since the last busy rise, and that count is set by the order of the stimulus.

// File: rtl/rdstat_pkg.sv
`timescale 1ns/1ps
package rdstat_pkg;
    typedef enum logic [1:0] {
        DRV_HIZ    = 2'd0,
        DRV_ARRAY  = 2'd1,
        DRV_STATUS = 2'd2
    } drv_mode_e;

    typedef enum logic {
        PRG_IDLE   = 1'b0,
        PRG_ACTIVE = 1'b1
    } prog_state_e;
endpackage

// File: rtl/rdstat_qual.sv
`timescale 1ns/1ps
module rdstat_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_active,
    output logic rd_start
);
    logic rd_prev_q;

    always_comb begin
        rd_active = !ce_n && !oe_n && we_n;
        rd_start  = rd_active && !rd_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_active;
    end
endmodule

// File: rtl/rdstat_prog_tracker.sv
`timescale 1ns/1ps
module rdstat_prog_tracker
    import rdstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_start,
    output logic tog_next
);
    prog_state_e state_q, state_d;
    logic        tog_q;
    logic        busy_rise;

    always_comb begin
        state_d   = state_q;
        busy_rise = 1'b0;
        unique case (state_q)
            PRG_IDLE: if (busy) begin
                state_d   = PRG_ACTIVE;
                busy_rise = 1'b1;
            end
            PRG_ACTIVE: if (!busy) state_d = PRG_IDLE;
            default: state_d = PRG_IDLE;
        endcase
        tog_next = (busy_rise ? 1'b0 : tog_q) ^ (busy && rd_start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PRG_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog_q <= 1'b0;
        else if (busy) tog_q <= tog_next;
    end

    assert_tog_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PRG_IDLE && busy && !rd_start) |=> (tog_q == 1'b0));

    assert_tog_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PRG_ACTIVE && busy && rd_start) |=> (tog_q != $past(tog_q)));

    assert_tog_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PRG_ACTIVE && !rd_start) |=> $stable(tog_q));
endmodule

// File: rtl/rdstat_encoder.sv
`timescale 1ns/1ps
module rdstat_encoder #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned TOG_BIT = DATA_W - 2
) (
    input  logic [DATA_W-1:0] last_byte,
    input  logic              tog,
    output logic [DATA_W-1:0] status_word
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == TOG_BIT) begin : g_tog
            assign status_word[i] = tog;
        end else begin : g_inv
            assign status_word[i] = ~last_byte[i];
        end
    end
endmodule

// File: rtl/rdstat_readback.sv
`timescale 1ns/1ps
module rdstat_readback
    import rdstat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              prog_busy,
    input  logic [DATA_W-1:0] last_wr_byte,
    input  logic [DATA_W-1:0] array_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    logic              rd_active, rd_start, tog_next;
    logic [DATA_W-1:0] status_word;
    logic [DATA_W-1:0] dq_q;
    drv_mode_e         mode_q, mode_d;

    rdstat_qual u_qual (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rd_active(rd_active), .rd_start(rd_start)
    );

    rdstat_prog_tracker u_track (
        .clk(clk), .rst_n(rst_n), .busy(prog_busy), .rd_start(rd_start),
        .tog_next(tog_next)
    );

    rdstat_encoder #(.DATA_W(DATA_W), .TOG_BIT(TOG_BIT)) u_enc (
        .last_byte(last_wr_byte), .tog(tog_next), .status_word(status_word)
    );

    always_comb begin
        if (!rd_active)     mode_d = DRV_HIZ;
        else if (prog_busy) mode_d = DRV_STATUS;
        else                mode_d = DRV_ARRAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= DRV_HIZ;
        else        mode_q <= mode_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dq_q <= '0;
        else begin
            unique case (mode_d)
                DRV_HIZ:    dq_q <= '0;
                DRV_ARRAY:  dq_q <= array_rdata;
                DRV_STATUS: dq_q <= status_word;
                default:    dq_q <= '0;
            endcase
        end
    end

    assign dq_out = dq_q;
    assign dq_oe  = (mode_q != DRV_HIZ);

    assert_hiz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce_n && !oe_n && we_n) |=> (!dq_oe && dq_out == '0));

    assert_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && !prog_busy) |=> (dq_oe && dq_out == $past(array_rdata)));

    assert_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && prog_busy) |=>
            (dq_oe && dq_out[POLL_BIT] == !$past(last_wr_byte[POLL_BIT])));

    assert_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && we_n && prog_busy) |=>
            (dq_out[TOG_BIT-1:0] == ~$past(last_wr_byte[TOG_BIT-1:0])));
endmodule

// File: tb/rdstat_readback_tb_top.sv
`timescale 1ns/1ps
module rdstat_readback_tb_top;
    localparam int W = 8;
    localparam int NV = 16;
    localparam int VW = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
    logic [W-1:0] last_b = '0, arr = '0;
    logic [W-1:0] dq_out;
    logic dq_oe;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rdstat_readback #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .prog_busy(busy), .last_wr_byte(last_b), .array_rdata(arr),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [VW-1:0] mk(logic c, logic o, logic w, logic b,
        logic [7:0] l, logic [7:0] a, logic eo, logic [7:0] ed);
        return {c, o, w, b, l, a, eo, ed};
    endfunction

    // fields: ce_n oe_n we_n busy last array exp_oe exp_dq
    localparam logic [VW-1:0] VEC [NV] = '{
        mk(1,1,1,0,8'h00,8'hA5,0,8'h00),  // R2 deselected
        mk(0,0,1,0,8'h00,8'hA5,1,8'hA5),  // R3
        mk(0,0,1,0,8'h00,8'h3C,1,8'h3C),  // R3
        mk(0,1,1,0,8'h00,8'h3C,0,8'h00),  // R2 oe_n high
        mk(0,0,0,0,8'h00,8'h3C,0,8'h00),  // R2 we_n low
        mk(1,1,1,1,8'h5A,8'hFF,0,8'h00),  // R7 busy rises, clears toggle
        mk(0,0,1,1,8'h5A,8'hFF,1,8'hE5),  // R4 R5 R6 toggle -> 1
        mk(0,0,1,1,8'h5A,8'hFF,1,8'hE5),  // R6 held read, no change
        mk(1,1,1,1,8'h5A,8'hFF,0,8'h00),  // R2
        mk(0,0,1,1,8'h5A,8'hFF,1,8'hA5),  // R6 toggle -> 0
        mk(1,1,1,1,8'h5A,8'hFF,0,8'h00),  // R2
        mk(0,0,1,1,8'h81,8'hFF,1,8'h7E),  // R4 R5 R6 toggle -> 1
        mk(1,1,1,0,8'h81,8'h81,0,8'h00),  // busy falls
        mk(0,0,1,0,8'h81,8'h81,1,8'h81),  // R8
        mk(1,1,1,0,8'h81,8'h81,0,8'h00),  // R2
        mk(0,0,1,0,8'h81,8'h81,1,8'h81)   // R8 bit 6 steady
    };

    task automatic check(input string req, input logic eo, input logic [7:0] ed);
        checks++;
        if (dq_oe !== eo || dq_out !== ed) begin
            errors++;
            $display("FAIL %s: dq_oe=%0b dq_out=%02h expected dq_oe=%0b dq_out=%02h",
                     req, dq_oe, dq_out, eo, ed);
        end
    endtask

    task automatic step(input logic c, input logic o, input logic w, input logic b,
        input logic [7:0] l, input logic [7:0] a, input logic eo, input logic [7:0] ed,
        input string req);
        ce_n = c; oe_n = o; we_n = w; busy = b; last_b = l; arr = a;
        @(posedge clk);
        @(negedge clk);
        check(req, eo, ed);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            step(v[28], v[27], v[26], v[25], v[24:17], v[16:9], v[8], v[7:0],
                 v[25] ? "R4/R5/R6 table" : "R2/R3/R8 table");
        end
        // R3 then R9: read held while busy rises -> status with bit 6 = 0
        step(0,0,1,0,8'h00,8'h11,1,8'h11,"R3 held read idle");
        step(0,0,1,1,8'h00,8'h11,1,8'hBF,"R9 busy rises under open read");
        step(1,1,1,1,8'h00,8'h11,0,8'h00,"R2 deselect");
        step(0,0,1,1,8'h00,8'h11,1,8'hFF,"R6 new read flips toggle");
        // R7: read start coincides with busy rise
        step(1,1,1,0,8'h00,8'h11,0,8'h00,"R2 deselect, busy low");
        step(0,0,1,1,8'h00,8'h11,1,8'hFF,"R7 start with busy rise");
        step(0,0,1,1,8'h00,8'h11,1,8'hFF,"R6 held read");
        // R1: reset applied mid-programming while reading
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset while busy", 1'b0, 8'h00);
        rst_n = 1'b1;
        step(1,1,1,0,8'h00,8'h00,0,8'h00,"R2 after reset");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule